// File: doc/BRIEF.md
# Systolic Matrix-Vector Multiplier

The block forms the product y = A·x of an n-by-n signed matrix and an n-element signed vector. It does this on a linear chain of n multiply-accumulate cells. Each cell keeps one vector element stationary. Partial sums step one cell to the right on every clock. The matrix arrives over a bus with one lane per cell, and the caller applies a time skew: row i reaches lane j one clock later than it reaches lane j-1. Each finished y element leaves the far end of the chain on a cycle of its own. Results come out in row order, with a valid flag and the row index.

The caller first writes the vector through a single-element preload port. It then pulses start together with the first matrix step and streams the skewed elements. The n results are collected from the output over n consecutive cycles. The matrix itself is never stored inside the block. All data enters and leaves only at the two ends of the chain.

Top module: `smv_array`

## Requirements
- R1: While rst_ni is low and after it is released, y_valid_o is 0, y_o is 0, and every stored vector element is 0.
- R2: A write with x_we_i high and x_addr_i below n stores x_wdata_i as vector element x_addr_i (0-based). A write with x_addr_i at n or above changes no stored element.
- R3: The rising edge on which start_i is high is counted as edge 1. Element a(i,j), with 1-based row i and column j, is sampled from lane j-1 on edge i+j-1. Lane k occupies bits a_i[k*DW +: DW].
- R4: y_i equals the sum over j of a(i,j)·x_j. Operands are DW-bit two's complement, and the sum is an AW-bit two's complement value on y_o.
- R5: y_i is presented on y_o right after edge n+i-1. So y_1 appears after edge n and y_n after edge 2n-1. y_idx_o then holds i-1.
- R6: y_valid_o is high for exactly n consecutive cycles, after edges n through 2n-1, with y_idx_o counting up from 0. It is low after every other edge.
- R7: Lane values on edges where no element is scheduled do not change any valid result.
- R8: A start_i pulse while a run is in progress restarts the step count from edge 1. Results of the abandoned run are never flagged valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Marks edge 1 of a run |
| x_we_i | input | 1 | Vector element write enable |
| x_addr_i | input | XAW | Vector element index |
| x_wdata_i | input | DW | Vector element value, signed |
| a_i | input | N*DW | Matrix lanes, one per cell |
| y_o | output | AW | Result element, signed |
| y_valid_o | output | 1 | Result valid |
| y_idx_o | output | IW | Row index of the current result |

## Verification
The checker watches the output window on every cycle. It confirms that the valid flag rises only with index 0, that the index then steps by one up to n-1, that the flag falls right after the last row, and that a start pulse clears it. It also checks, on every cycle, how each preload write affects the stored vector, both for addresses in range and out of range. Only the bench scenarios can show that the values are arithmetically right under the skew schedule. They also show that junk on unscheduled lane slots leaves the results unchanged, and that a restarted run is not polluted by partial sums still in the chain. The bench compares these against sums it computes itself.

// File: rtl/smv_pkg.sv
package smv_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } smv_state_e;
endpackage

// File: rtl/smv_cell.sv
module smv_cell #(
  parameter int DW  = 8,
  parameter int AW  = 20,
  parameter int XAW = 3,
  parameter int IDX = 0
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           x_we_i,
  input  logic [XAW-1:0] x_addr_i,
  input  logic [DW-1:0]  x_wdata_i,
  input  logic [DW-1:0]  a_i,
  input  logic [AW-1:0]  psum_i,
  output logic [AW-1:0]  psum_o,
  output logic [DW-1:0]  x_o
);
  localparam int PW = 2 * DW;

  logic [DW-1:0]        x_q;
  logic [AW-1:0]        psum_q;
  logic signed [PW-1:0] prod;
  logic [AW-1:0]        prod_ext;

  assign prod     = $signed(a_i) * $signed(x_q);
  assign prod_ext = {{(AW-PW){prod[PW-1]}}, prod};

  // stationary operand; full-width compare rejects out-of-range indices
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) x_q <= '0;
    else if (x_we_i && (x_addr_i == XAW'(IDX))) x_q <= x_wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) psum_q <= '0;
    else         psum_q <= psum_i + prod_ext;
  end

  assign psum_o = psum_q;
  assign x_o    = x_q;
endmodule

// File: rtl/smv_ctrl.sv
module smv_ctrl
  import smv_pkg::*;
#(
  parameter int N  = 4,
  parameter int IW = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  output logic          valid_o,
  output logic [IW-1:0] idx_o
);
  localparam int CW   = $clog2(2 * N) + 1;
  localparam int LAST = 2 * N - 1;

  smv_state_e    state_q;
  logic [CW-1:0] cnt_q;

  // cnt_q = number of edges since (and including) the start edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else if (start_i) begin
      state_q <= ST_RUN;
      cnt_q   <= CW'(1);
    end else if (state_q == ST_RUN) begin
      if (cnt_q == CW'(LAST)) begin
        state_q <= ST_IDLE;
        cnt_q   <= '0;
      end else begin
        cnt_q <= cnt_q + CW'(1);
      end
    end
  end

  assign valid_o = (state_q == ST_RUN) && (cnt_q >= CW'(N));
  assign idx_o   = valid_o ? IW'(cnt_q - CW'(N)) : '0;
endmodule

// File: rtl/smv_array.sv
module smv_array #(
  parameter int N   = 4,
  parameter int DW  = 8,
  parameter int AW  = 20,
  parameter int XAW = $clog2(N) + 1,
  parameter int IW  = (N > 1) ? $clog2(N) : 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic            x_we_i,
  input  logic [XAW-1:0]  x_addr_i,
  input  logic [DW-1:0]   x_wdata_i,
  input  logic [N*DW-1:0] a_i,
  output logic [AW-1:0]   y_o,
  output logic            y_valid_o,
  output logic [IW-1:0]   y_idx_o
);
  logic [AW-1:0]   psum [N+1];
  logic [N*DW-1:0] x_flat;

  assign psum[0] = '0;

  for (genvar k = 0; k < N; k++) begin : g_cell
    smv_cell #(
      .DW (DW),
      .AW (AW),
      .XAW(XAW),
      .IDX(k)
    ) u_cell (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .x_we_i   (x_we_i),
      .x_addr_i (x_addr_i),
      .x_wdata_i(x_wdata_i),
      .a_i      (a_i[k*DW +: DW]),
      .psum_i   (psum[k]),
      .psum_o   (psum[k+1]),
      .x_o      (x_flat[k*DW +: DW])
    );
  end

  smv_ctrl #(
    .N (N),
    .IW(IW)
  ) u_ctrl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start_i),
    .valid_o(y_valid_o),
    .idx_o  (y_idx_o)
  );

  // last cell register is the boundary output
  assign y_o = psum[N];
endmodule

// File: rtl/smv_chk.sv
module smv_chk #(
  parameter int N   = 4,
  parameter int DW  = 8,
  parameter int AW  = 20,
  parameter int XAW = 3,
  parameter int IW  = 2
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            start_i,
  input logic            x_we_i,
  input logic [XAW-1:0]  x_addr_i,
  input logic [DW-1:0]   x_wdata_i,
  input logic            y_valid_o,
  input logic [IW-1:0]   y_idx_o,
  input logic [N*DW-1:0] x_flat
);
  // R6
  first_row_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(y_valid_o) |-> (y_idx_o == '0));

  // R6
  row_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (y_valid_o && (y_idx_o != IW'(N-1)) && !start_i)
      |=> (y_valid_o && (y_idx_o == $past(y_idx_o) + IW'(1))));

  // R6
  window_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (y_valid_o && (y_idx_o == IW'(N-1)) && !start_i) |=> !y_valid_o);

  // R8
  restart_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && (N > 1)) |=> !y_valid_o);

  // R2
  x_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (x_we_i && (x_addr_i < XAW'(N)))
      |=> (x_flat[$past(x_addr_i)*DW +: DW] == $past(x_wdata_i)));

  // R2
  x_ignore_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(x_we_i && (x_addr_i < XAW'(N))) |=> $stable(x_flat));
endmodule

bind smv_array smv_chk #(
  .N  (N),
  .DW (DW),
  .AW (AW),
  .XAW(XAW),
  .IW (IW)
) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .start_i  (start_i),
  .x_we_i   (x_we_i),
  .x_addr_i (x_addr_i),
  .x_wdata_i(x_wdata_i),
  .y_valid_o(y_valid_o),
  .y_idx_o  (y_idx_o),
  .x_flat   (x_flat)
);

// File: tb/tb_smv_array.sv
module tb_smv_array;
  localparam int N   = 4;
  localparam int DW  = 8;
  localparam int AW  = 20;
  localparam int XAW = $clog2(N) + 1;
  localparam int IW  = $clog2(N);

  logic            clk_i = 1'b0;
  logic            rst_ni = 1'b0;
  logic            start_i = 1'b0;
  logic            x_we_i = 1'b0;
  logic [XAW-1:0]  x_addr_i = '0;
  logic [DW-1:0]   x_wdata_i = '0;
  logic [N*DW-1:0] a_i = '0;
  logic [AW-1:0]   y_o;
  logic            y_valid_o;
  logic [IW-1:0]   y_idx_o;

  int  am [N][N];
  int  xv [N];
  bit  junk = 1'b0;
  string val_req = "R4";
  int  pass_cnt = 0;
  int  fail_cnt = 0;
  bit  done = 1'b0;

  always #10 clk_i = ~clk_i;

  smv_array #(.N(N), .DW(DW), .AW(AW)) dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i),
    .x_we_i(x_we_i), .x_addr_i(x_addr_i), .x_wdata_i(x_wdata_i),
    .a_i(a_i), .y_o(y_o), .y_valid_o(y_valid_o), .y_idx_o(y_idx_o)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    if (ok) pass_cnt++;
    else begin
      fail_cnt++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int w8(input int v);
    logic [7:0] b;
    b = v[7:0];
    return int'($signed(b));
  endfunction

  task automatic load_x();
    for (int j = 0; j < N; j++) begin
      @(negedge clk_i);
      x_we_i = 1'b1; x_addr_i = XAW'(j); x_wdata_i = DW'(xv[j]);
    end
    // out-of-range writes must be dropped (R2)
    for (int j = N; j < 2 * N; j++) begin
      @(negedge clk_i);
      x_we_i = 1'b1; x_addr_i = XAW'(j); x_wdata_i = 8'h5a;
    end
    @(negedge clk_i);
    x_we_i = 1'b0;
  endtask

  // inputs for edge k (edge 1 = start edge), R3 skew
  task automatic drive(input int k);
    start_i = (k == 1);
    for (int jj = 0; jj < N; jj++) begin
      int r;
      r = k - jj;
      if (k >= 1 && r >= 1 && r <= N) a_i[jj*DW +: DW] = DW'(am[r-1][jj]);
      else if (junk)                  a_i[jj*DW +: DW] = DW'($urandom);
      else                            a_i[jj*DW +: DW] = '0;
    end
  endtask

  // outputs after edge k
  task automatic check_out(input int k);
    bit exp_v;
    exp_v = (k >= N) && (k <= 2 * N - 1);
    chk(y_valid_o == exp_v, "R6", $sformatf("valid after edge %0d", k),
        int'(y_valid_o), int'(exp_v));
    if (exp_v) begin
      int r, e;
      r = k - N;
      e = 0;
      for (int j = 0; j < N; j++) e += am[r][j] * xv[j];
      chk(y_idx_o == IW'(r), "R5", $sformatf("index after edge %0d", k),
          int'(y_idx_o), r);
      chk(int'($signed(y_o)) == e, val_req, $sformatf("y row %0d", r),
          int'($signed(y_o)), e);
    end
  endtask

  task automatic run();
    for (int k = 1; k <= 2 * N + 1; k++) begin
      @(negedge clk_i);
      if (k > 1) check_out(k - 1);
      drive(k);
    end
    @(negedge clk_i);
    check_out(2 * N + 1);
    drive(0);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      fail_cnt++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("%0d/%0d checks passed", pass_cnt, pass_cnt + fail_cnt);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    repeat (3) @(negedge clk_i);
    chk(y_valid_o == 1'b0, "R1", "valid in reset", int'(y_valid_o), 0);
    chk(y_o == '0, "R1", "y in reset", int'(y_o), 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    chk(y_valid_o == 1'b0, "R1", "valid after reset", int'(y_valid_o), 0);
    // R1: stored vector is zero, so any matrix yields zero
    for (int i = 0; i < N; i++) begin
      xv[i] = 0;
      for (int j = 0; j < N; j++) am[i][j] = 17 * i - 9 * j + 3;
    end
    val_req = "R1";
    run();

    // R2 preload with out-of-range writes, R3 identity reveals lane skew
    for (int i = 0; i < N; i++) begin
      xv[i] = i + 1;
      for (int j = 0; j < N; j++) am[i][j] = (i == j) ? 1 : 0;
    end
    load_x();
    val_req = "R2";
    run();
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++) am[i][j] = (j == N - 1 - i) ? 1 : 0;
    val_req = "R3";
    run();
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++) am[i][j] = 10 * i + j - 20;
    run();

    // R4 extremes
    val_req = "R4";
    for (int j = 0; j < N; j++) xv[j] = 127;
    load_x();
    for (int i = 0; i < N; i++) for (int j = 0; j < N; j++) am[i][j] = 127;
    run();
    for (int j = 0; j < N; j++) xv[j] = -128;
    load_x();
    for (int i = 0; i < N; i++) for (int j = 0; j < N; j++) am[i][j] = -128;
    run();
    for (int i = 0; i < N; i++) for (int j = 0; j < N; j++) am[i][j] = 127;
    run();

    // R4 sweep over operand values
    for (int v = -128; v <= 127; v += 15) begin
      for (int j = 0; j < N; j++) xv[j] = w8(v * 7 + j * 31);
      load_x();
      for (int i = 0; i < N; i++)
        for (int j = 0; j < N; j++) am[i][j] = w8(v + 37 * i - 53 * j);
      run();
    end

    // R7 junk on unscheduled slots
    junk = 1'b1;
    val_req = "R7";
    for (int s = 0; s < 6; s++) begin
      for (int i = 0; i < N; i++)
        for (int j = 0; j < N; j++) am[i][j] = w8(s * 41 + 13 * i * j - 7 * i);
      run();
    end
    junk = 1'b0;

    // R8 restart mid-run: old run abandoned after 3 edges
    for (int i = 0; i < N; i++) for (int j = 0; j < N; j++) am[i][j] = 99;
    for (int k = 1; k <= 3; k++) begin
      @(negedge clk_i);
      if (k > 1) chk(y_valid_o == 1'b0, "R8", "valid before restart", int'(y_valid_o), 0);
      drive(k);
    end
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++) am[i][j] = w8(5 * i - 11 * j + 2);
    val_req = "R8";
    run();

    done = 1'b1;
    $display("%0d/%0d checks passed", pass_cnt, pass_cnt + fail_cnt);
    $finish;
  end
endmodule